// File: doc/BRIEF.md
# Multiplexed External Memory Bus Bridge

This block sits between a small 8-bit processor core and memory outside the chip. The core asks for one access at a time: a code fetch, a data read or a data write, at a 16-bit address. The bridge turns each request into a fixed sequence of bus phases. The low address byte and the data byte take turns on one shared bidirectional port. While the low byte is on the port, a latch strobe lets external logic hold it. The high address byte goes out on a port of its own. The read data, or a completion pulse for a write, returns to the core.

Code fetches and data accesses use separate active-low strobes, so external code memory and data memory can share the bus without decoding. A select input decides where code fetches go. With select low, a fetch runs on the external bus. With select high, the fetch is served from an internal code store and the external bus stays quiet. Data accesses always run on the external bus.

Top module: `xbus_bridge`

## Requirements
- R1: After reset, `aleOut` is 0, `progStrobeN`, `rdStrobeN` and `wrStrobeN` are 1, the shared port is released, `highAddr` is 0, `rspDone` is 0 and `rspData` is 0.
- R2: An external access accepted at a clock edge drives `reqAddr[7:0]` on `adBus` for the next two cycles. `aleOut` is 1 in the first of these cycles only and 0 in the second.
- R3: During the four cycles after acceptance of an external access, `highAddr` equals `reqAddr[15:8]`. It is 0 in all other cycles.
- R4: An external code fetch (`reqKind` 2'b00 with `selInternal` 0) holds `progStrobeN` low in cycles 3 and 4 after acceptance. `rdStrobeN` and `wrStrobeN` stay high.
- R5: A data read (`reqKind` 2'b01) holds `rdStrobeN` low in cycles 3 and 4 after acceptance. `progStrobeN` stays high. The bridge releases `adBus` while a read or code strobe is low.
- R6: A data write (`reqKind` 2'b10) holds `wrStrobeN` low in cycles 3 and 4 after acceptance. `adBus` carries `reqWdata` in both cycles.
- R7: For an external read or fetch, `adBus` is sampled at the edge that ends cycle 4. In cycle 5 all strobes are high and `rspDone` is 1 for exactly that cycle. `rspData` holds the last captured value until the next capture.
- R8: A code fetch with `selInternal` 1 causes no external bus activity. `intAddr` equals the fetch address in cycle 1 after acceptance. `intData` is sampled at the end of cycle 1, and `rspDone` pulses in cycle 2 with that value on `rspData`.
- R9: A request presented while an access is in progress, including its done cycle, has no effect. The next request is accepted at the first edge after the done cycle.
- R10: A request with `reqKind` 2'b11 is not accepted. It produces no bus activity and no `rspDone`.
- R11: `selInternal` affects code fetches only. A data read or write with `selInternal` 1 runs on the external bus.
- R12: At most one of the three active-low strobes is low in any cycle. None of them is low while `aleOut` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe from the core |
| reqKind | input | 2 | 00 code fetch, 01 data read, 10 data write, 11 reserved |
| reqAddr | input | 16 | Access address |
| reqWdata | input | 8 | Write data |
| selInternal | input | 1 | 1: code fetches use the internal code store |
| intData | input | 8 | Byte returned by the internal code store |
| intAddr | output | 16 | Address presented to the internal code store |
| rspData | output | 8 | Captured read data |
| rspDone | output | 1 | One-cycle completion pulse |
| adBus | inout | 8 | Shared low-address and data port |
| highAddr | output | 8 | High address byte |
| aleOut | output | 1 | Address latch strobe, active high |
| progStrobeN | output | 1 | External code read strobe, active low |
| rdStrobeN | output | 1 | Data read strobe, active low |
| wrStrobeN | output | 1 | Data write strobe, active low |

## Verification
The bench builds the bridge with its default widths: a 16-bit address and an 8-bit data byte. This gives a full 8-bit high-address port and the corner addresses 16'h0000 and 16'hFFFF. A bus memory model in the bench latches the low byte on the latch strobe and answers reads from both address bytes, so any mix-up between the two bytes changes the read data. Requests held high for many cycles check acceptance only in idle cycles. Reserved kinds and select changes on data accesses are checked against a cycle model that tracks which access phase the bridge should be in.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_RSVD  = 2'b11
  } reqKind_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_HOLD,
    PH_STRB,
    PH_LAST,
    PH_INTRD,
    PH_DONE
  } phase_t;

  typedef struct packed {
    logic loadReq;
    logic ale;
    logic driveAddr;
    logic driveData;
    logic busHigh;
    logic progOn;
    logic rdOn;
    logic wrOn;
    logic capBus;
    logic capInt;
    logic done;
  } strobes_t;

endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       selInternal,
  output strobes_t   st
);

  phase_t   phase, phaseNext;
  reqKind_t kindQ;
  reqKind_t kindIn;
  logic     accept;

  assign kindIn = reqKind_t'(reqKind);
  assign accept = (phase == PH_IDLE) && reqValid && (kindIn != KIND_RSVD);

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: begin
        if (accept) begin
          if (kindIn == KIND_FETCH && selInternal) phaseNext = PH_INTRD;
          else phaseNext = PH_ADDR;
        end
      end
      PH_ADDR:  phaseNext = PH_HOLD;
      PH_HOLD:  phaseNext = PH_STRB;
      PH_STRB:  phaseNext = PH_LAST;
      PH_LAST:  phaseNext = PH_DONE;
      PH_INTRD: phaseNext = PH_DONE;
      PH_DONE:  phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      kindQ <= KIND_FETCH;
    end else begin
      phase <= phaseNext;
      if (accept) kindQ <= kindIn;
    end
  end

  logic inStrobe;
  assign inStrobe = (phase == PH_STRB) || (phase == PH_LAST);

  always_comb begin
    st           = '0;
    st.loadReq   = accept;
    st.ale       = (phase == PH_ADDR);
    st.driveAddr = (phase == PH_ADDR) || (phase == PH_HOLD);
    st.busHigh   = (phase == PH_ADDR) || (phase == PH_HOLD) || inStrobe;
    st.progOn    = inStrobe && (kindQ == KIND_FETCH);
    st.rdOn      = inStrobe && (kindQ == KIND_READ);
    st.wrOn      = inStrobe && (kindQ == KIND_WRITE);
    st.driveData = inStrobe && (kindQ == KIND_WRITE);
    st.capBus    = (phase == PH_LAST) && (kindQ != KIND_WRITE);
    st.capInt    = (phase == PH_INTRD);
    st.done      = (phase == PH_DONE);
  end

endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HIGH_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] intData,
  input  logic [DATA_W-1:0] busIn,
  output logic [ADDR_W-1:0] intAddr,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [HIGH_W-1:0] highAddr,
  output logic              aleOut,
  output logic              progStrobeN,
  output logic              rdStrobeN,
  output logic              wrStrobeN,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDone
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rspQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rspQ   <= '0;
    end else begin
      if (st.loadReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (st.capBus) rspQ <= busIn;
      else if (st.capInt) rspQ <= intData;
    end
  end

  assign busOe       = st.driveAddr || st.driveData;
  assign busOut      = st.driveData ? wdataQ : addrQ[DATA_W-1:0];
  assign highAddr    = st.busHigh ? addrQ[ADDR_W-1:DATA_W] : '0;
  assign intAddr     = addrQ;
  assign aleOut      = st.ale;
  assign progStrobeN = ~st.progOn;
  assign rdStrobeN   = ~st.rdOn;
  assign wrStrobeN   = ~st.wrOn;
  assign rspData     = rspQ;
  assign rspDone     = st.done;

endmodule

// File: rtl/xbus_bridge.sv
module xbus_bridge
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HIGH_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              selInternal,
  input  logic [DATA_W-1:0] intData,
  output logic [ADDR_W-1:0] intAddr,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDone,
  inout  wire  [DATA_W-1:0] adBus,
  output logic [HIGH_W-1:0] highAddr,
  output logic              aleOut,
  output logic              progStrobeN,
  output logic              rdStrobeN,
  output logic              wrStrobeN
);

  strobes_t          st;
  logic [DATA_W-1:0] busOut;
  logic              busOe;

  xbus_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqKind     (reqKind),
    .selInternal (selInternal),
    .st          (st)
  );

  xbus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .intData     (intData),
    .busIn       (adBus),
    .intAddr     (intAddr),
    .busOut      (busOut),
    .busOe       (busOe),
    .highAddr    (highAddr),
    .aleOut      (aleOut),
    .progStrobeN (progStrobeN),
    .rdStrobeN   (rdStrobeN),
    .wrStrobeN   (wrStrobeN),
    .rspData     (rspData),
    .rspDone     (rspDone)
  );

  assign adBus = busOe ? busOut : 'z;

endmodule

// File: rtl/xbus_chk.sv
module xbus_chk (
  input logic clk,
  input logic rstN,
  input logic aleOut,
  input logic progStrobeN,
  input logic rdStrobeN,
  input logic wrStrobeN,
  input logic rspDone,
  input logic busOe
);

  // R12: strobes mutually exclusive
  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    $countones({~progStrobeN, ~rdStrobeN, ~wrStrobeN}) <= 1);

  // R12: latch strobe never overlaps an access strobe
  assert_ale_alone_R12: assert property (@(posedge clk) disable iff (!rstN)
    aleOut |-> (progStrobeN && rdStrobeN && wrStrobeN));

  // R2: latch strobe lasts a single cycle
  assert_ale_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    aleOut |=> !aleOut);

  // R5: port released while memory drives it
  assert_read_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStrobeN || !progStrobeN) |-> !busOe);

  // R6: port driven during the write strobe
  assert_write_drive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobeN |-> busOe);

  // R7: done is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R7: strobes released by the done cycle
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> (progStrobeN && rdStrobeN && wrStrobeN && !aleOut));

  // R4: code strobe stays low for two cycles
  assert_prog_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(progStrobeN) |=> !progStrobeN);

endmodule

bind xbus_bridge xbus_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .aleOut      (aleOut),
  .progStrobeN (progStrobeN),
  .rdStrobeN   (rdStrobeN),
  .wrStrobeN   (wrStrobeN),
  .rspDone     (rspDone),
  .busOe       (busOe)
);

// File: tb/tb_xbus_bridge.sv
module tb_xbus_bridge;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'b00;
  logic [15:0] reqAddr = 16'h0;
  logic [7:0]  reqWdata = 8'h0;
  logic        selInternal = 1'b0;
  logic [7:0]  intData;
  logic [15:0] intAddr;
  logic [7:0]  rspData;
  logic        rspDone;
  wire  [7:0]  adBus;
  logic [7:0]  highAddr;
  logic        aleOut, progStrobeN, rdStrobeN, wrStrobeN;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_bridge dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .selInternal(selInternal),
    .intData(intData), .intAddr(intAddr), .rspData(rspData),
    .rspDone(rspDone), .adBus(adBus), .highAddr(highAddr),
    .aleOut(aleOut), .progStrobeN(progStrobeN), .rdStrobeN(rdStrobeN),
    .wrStrobeN(wrStrobeN)
  );

  function automatic logic [7:0] memFunc(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] intFunc(input logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h11;
  endfunction

  // external memory model: latch low byte on ale, answer reads
  logic [7:0] latchLo = 8'h0;
  always @(posedge clk) if (aleOut) latchLo <= adBus;
  assign adBus = (!progStrobeN || !rdStrobeN) ? memFunc({highAddr, latchLo}) : 8'hzz;
  assign intData = intFunc(intAddr);

  int    total = 0;
  int    bad = 0;
  string scen = "R1";
  bit    finished = 0;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s (scenario %s) at %0t: act=%h exp=%h", tag, scen, $time, act, exp);
    end
  endtask

  // reference model: phase counter per accepted access
  int          mc = 0;
  bit          mExt = 0;
  logic [1:0]  mk = 0;
  logic [15:0] ma = 0;
  logic [7:0]  mw = 0;
  logic [7:0]  mr = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mc = 0; mr = 8'h0;
    end else if (mc == 0) begin
      if (reqValid && reqKind != 2'b11) begin
        mc = 1; mk = reqKind; ma = reqAddr; mw = reqWdata;
        mExt = !(reqKind == 2'b00 && selInternal);
      end
    end else begin
      if (mExt && mc == 4 && mk != 2'b10) mr = memFunc(ma);
      if (!mExt && mc == 1) mr = intFunc(ma);
      mc++;
      if ((mExt && mc == 6) || (!mExt && mc == 3)) mc = 0;
    end
  end

  always @(negedge clk) begin
    bit strb, eAle, eProgN, eRdN, eWrN, eDone;
    logic [7:0] eHigh;
    strb   = mExt && (mc == 3 || mc == 4);
    eAle   = mExt && mc == 1;
    eProgN = !(strb && mk == 2'b00);
    eRdN   = !(strb && mk == 2'b01);
    eWrN   = !(strb && mk == 2'b10);
    eHigh  = (mExt && mc >= 1 && mc <= 4) ? ma[15:8] : 8'h00;
    eDone  = (mExt && mc == 5) || (!mExt && mc == 2);
    if (!rstN) begin
      check(aleOut == 0 && progStrobeN && rdStrobeN && wrStrobeN && !rspDone,
            "R1", {11'b0, aleOut, progStrobeN, rdStrobeN, wrStrobeN, rspDone}, 16'h000E);
    end else begin
      check(aleOut == eAle, "R2", 16'(aleOut), 16'(eAle));
      check(highAddr == eHigh, "R3", 16'(highAddr), 16'(eHigh));
      check(progStrobeN == eProgN, "R4", 16'(progStrobeN), 16'(eProgN));
      check(rdStrobeN == eRdN, "R5", 16'(rdStrobeN), 16'(eRdN));
      check(wrStrobeN == eWrN, "R6", 16'(wrStrobeN), 16'(eWrN));
      check(rspDone == eDone, "R7", 16'(rspDone), 16'(eDone));
      check(rspData == mr, "R7", 16'(rspData), 16'(mr));
      if (mExt && (mc == 1 || mc == 2))
        check(adBus == ma[7:0], "R2", 16'(adBus), 16'(ma[7:0]));
      if (mExt && mk == 2'b10 && strb)
        check(adBus == mw, "R6", 16'(adBus), 16'(mw));
      if (!mExt && mc == 1)
        check(intAddr == ma, "R8", intAddr, ma);
    end
  end

  task automatic req(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d,
                     input bit s, input int hold, input int gap);
    @(negedge clk); #1;
    reqValid = 1; reqKind = k; reqAddr = a; reqWdata = d; selInternal = s;
    repeat (hold) @(negedge clk);
    #1 reqValid = 0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1 rstN = 1;
    scen = "R4"; req(2'b00, 16'h1234, 8'h00, 0, 1, 8);
    scen = "R5"; req(2'b01, 16'hABCD, 8'h00, 0, 1, 8);
    scen = "R6"; req(2'b10, 16'h00FF, 8'h3C, 0, 1, 8);
    scen = "R8"; req(2'b00, 16'h4321, 8'h00, 1, 1, 6);
    scen = "R11"; req(2'b01, 16'h8001, 8'h00, 1, 1, 8);
    scen = "R11"; req(2'b10, 16'h7E02, 8'hA5, 1, 1, 8);
    scen = "R10"; req(2'b11, 16'h5555, 8'h77, 0, 3, 6);
    scen = "R9"; req(2'b01, 16'h1111, 8'h00, 0, 13, 8);
    scen = "R9"; req(2'b00, 16'h2468, 8'h00, 1, 7, 6);
    scen = "R3"; req(2'b10, 16'hFFFF, 8'hC3, 0, 1, 8);
    scen = "R3"; req(2'b00, 16'h0000, 8'h00, 0, 1, 8);
    scen = "R7"; req(2'b01, 16'hFFFF, 8'h00, 0, 1, 8);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule